// File: doc/BRIEF.md
# Clamp fault localizer for a five-level clamped leg

This block identifies the failed part of a single-phase five-level clamped inverter leg once a detector has reported an open-circuit fault. The leg has two three-level half-bridges (A and B). Each half has an outer-top, an inner-top, an inner-bottom and an outer-bottom switch, plus an upper and a lower clamping diode. The terminal voltage is half A minus half B. The block starts from the last healthy switching state and the sign of the load current. It keeps a set of twelve suspects and drops every suspect whose predicted terminal level differs from the measured quantified level.

If more than one suspect is left, the block probes the stage. It takes over the gate vector and moves a half that sits at its neutral position to the switch-only position that the current direction allows. After a settling window it compares again. At most two probes are made. When a single suspect is left, the block reports that part's code. When none is left, or the probes are used up, it reports code 0 (unidentified).

Top module: `clamp_fault_localizer`

## Requirements
- R1: After reset `busy`, `done`, `fault_id` and `probe_gates` are all 0.
- R2: Gate bits run from bit 7 down to bit 0 as A outer-top, A inner-top, A inner-bottom, A outer-bottom, then the same four for B. A half at high, neutral or low drives the nibble 1100, 0110 or 0011. States 1..9 are (A,B) = (high,low), (high,neutral), (neutral,low), (high,high), (neutral,neutral), (low,low), (neutral,high), (low,neutral), (low,high). A `detect_pulse` in idle with a valid state sets `busy` on the next edge and drives that state's gate pattern on `probe_gates`.
- R3: The level is sampled only on the last cycle of a window of SETTLE_CYC cycles that starts with each step; earlier values have no effect. `done` rises n*(SETTLE_CYC+1) edges after the edge that accepts the pulse, where n is the number of steps.
- R4: Level codes are 0 = -Vdc, 1 = -Vdc/2, 2 = 0, 3 = +Vdc/2, 4 = +Vdc. A unique match in step one ends the sequence: state 2 with positive current and code 1 gives A inner-top (64); state 3 with positive current and code 1 gives B inner-bottom (2).
- R5: State 5 with positive current and code 1 probes 0xC6, then 0xC3 if needed. Codes 1, 3 after the first probe give A inner-top (64) and A upper diode (3). Codes 2, 2 then 2 give B inner-bottom (2), and 2 then 4 give the B lower diode (81).
- R6: State 5 with negative current and code 3 probes 0x36, then 0x3C if needed. Code 1 after the first probe gives the A lower diode (9). Codes 2 then 2 give B inner-top (4), and 2 then 0 give the B upper diode (27).
- R7: State 2 with positive current and code 2 probes 0xC3; code 3 then gives A outer-top (128) and code 4 the B lower diode (81).
- R8: State 8 with positive current and code 0 probes 0x33; code 0 then gives B inner-bottom (2) and code 2 the B lower diode (81).
- R9: A level no suspect predicts, or suspects left with no half at neutral to probe, ends the sequence with `fault_id` 0.
- R10: A state code of 0 or above 9 completes on the accepting edge with `fault_id` 0, without raising `busy`.
- R11: `detect_pulse` while `busy` has no effect on the gates, the result or its timing.
- R12: Codes are 128, 64, 32, 16 for the A switches (outer-top to outer-bottom), 8, 4, 2, 1 for the B switches, and 3, 9, 27, 81 for the A upper, A lower, B upper and B lower diodes.
- R13: `done` is a one-cycle pulse with `busy` low. `probe_gates` is 0 while idle. `fault_id` changes only with `done` and holds until the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| detect_pulse | input | 1 | Fault detected, starts a localization |
| last_state | input | 4 | Last healthy switching state, 1..9 |
| cur_pos | input | 1 | 1 when the load current leaves the A terminal |
| level_code | input | 3 | Quantified terminal level code |
| probe_gates | output | 8 | Gate vector the stage must apply while busy |
| busy | output | 1 | Localization in progress |
| done | output | 1 | One-cycle completion pulse |
| fault_id | output | 8 | Code of the failed part, 0 if unidentified |

## Verification
The bench acts as the power stage. On every gate change it first shows a junk level for half a settling window and then the level the scenario prescribes. A design that samples too early therefore reports 0 or the wrong part, and one that samples late misses the exact completion cycle. The bench drives every ambiguous family through its full probe chain and checks the probe vectors in order. A design that probes the wrong half, or probes again after a unique match, fails on the gate sequence. Unmatched levels, a probe-less ambiguity and illegal state codes must yield code 0. A pulse fired mid-sequence must not restart or redirect the run.

// File: rtl/clamp_fault_localizer.sv
module clamp_fault_localizer #(
  parameter int SETTLE_CYC = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       detect_pulse,
  input  logic [3:0] last_state,
  input  logic       cur_pos,
  input  logic [2:0] level_code,
  output logic [7:0] probe_gates,
  output logic       busy,
  output logic       done,
  output logic [7:0] fault_id
);
  localparam int NCOMP = 12;
  localparam int CW = $clog2(SETTLE_CYC + 1);
  localparam logic [3:0] HALF_HI = 4'b1100;
  localparam logic [3:0] HALF_MID = 4'b0110;
  localparam logic [3:0] HALF_LO = 4'b0011;

  typedef enum logic [1:0] {IDLE, SETTLE, DECIDE} phase_t;

  phase_t            phase;
  logic [7:0]        g_now;
  logic              pos_q;
  logic [NCOMP-1:0]  suspects, match;
  logic [CW-1:0]     cnt;

  function automatic logic [7:0] state_gates(input logic [3:0] s);
    case (s)
      4'd1: return {HALF_HI, HALF_LO};
      4'd2: return {HALF_HI, HALF_MID};
      4'd3: return {HALF_MID, HALF_LO};
      4'd4: return {HALF_HI, HALF_HI};
      4'd5: return {HALF_MID, HALF_MID};
      4'd6: return {HALF_LO, HALF_LO};
      4'd7: return {HALF_MID, HALF_HI};
      4'd8: return {HALF_LO, HALF_MID};
      4'd9: return {HALF_LO, HALF_HI};
      default: return 8'h00;
    endcase
  endfunction

  // f = {outer-top, inner-top, inner-bottom, outer-bottom, upper diode, lower diode} open
  function automatic int half_level(input logic [3:0] g, input logic out, input logic [5:0] f);
    if (out) begin
      if (g[2] && !f[4]) return (g[3] && !f[5]) ? 1 : (f[1] ? -1 : 0);
      return -1;
    end
    if (g[1] && !f[3]) return (g[0] && !f[2]) ? -1 : (f[0] ? 1 : 0);
    return 1;
  endfunction

  function automatic logic [2:0] predict(input logic [7:0] g, input logic pos, input int c);
    logic [NCOMP-1:0] oh;
    int v;
    oh = NCOMP'(1) << c;
    v = half_level(g[7:4], pos, {oh[0], oh[1], oh[2], oh[3], oh[8], oh[9]})
      - half_level(g[3:0], !pos, {oh[4], oh[5], oh[6], oh[7], oh[10], oh[11]});
    return 3'(v + 2);
  endfunction

  function automatic logic [7:0] part_code(input int c);
    if (c < 8) return 8'(128 >> c);
    case (c)
      8: return 8'd3;
      9: return 8'd9;
      10: return 8'd27;
      default: return 8'd81;
    endcase
  endfunction

  function automatic logic [7:0] code_of(input logic [NCOMP-1:0] m);
    for (int c = 0; c < NCOMP; c++)
      if (m[c]) return part_code(c);
    return 8'd0;
  endfunction

  for (genvar c = 0; c < NCOMP; c++) begin : g_cmp
    assign match[c] = (predict(g_now, pos_q, c) == level_code);
  end

  wire state_ok = (last_state >= 4'd1) && (last_state <= 4'd9);
  wire single   = (suspects != '0) && ((suspects & (suspects - NCOMP'(1))) == '0);

  assign busy        = (phase != IDLE);
  assign probe_gates = busy ? g_now : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= IDLE;
      g_now    <= 8'h00;
      pos_q    <= 1'b0;
      suspects <= '0;
      cnt      <= '0;
      done     <= 1'b0;
      fault_id <= 8'h00;
    end else begin
      done <= 1'b0;
      case (phase)
        IDLE: if (detect_pulse) begin
          if (state_ok) begin
            g_now    <= state_gates(last_state);
            pos_q    <= cur_pos;
            suspects <= '1;
            cnt      <= '0;
            phase    <= SETTLE;
          end else begin
            done     <= 1'b1;
            fault_id <= 8'h00;
          end
        end
        SETTLE: begin
          if (cnt == CW'(SETTLE_CYC - 1)) begin
            suspects <= suspects & match;
            phase    <= DECIDE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          cnt <= '0;
          if (single || suspects == '0) begin
            fault_id <= code_of(suspects);
            done     <= 1'b1;
            phase    <= IDLE;
          end else if (g_now[7:4] == HALF_MID) begin
            g_now[7:4] <= pos_q ? HALF_HI : HALF_LO;
            phase      <= SETTLE;
          end else if (g_now[3:0] == HALF_MID) begin
            g_now[3:0] <= pos_q ? HALF_LO : HALF_HI;
            phase      <= SETTLE;
          end else begin
            fault_id <= 8'h00;
            done     <= 1'b1;
            phase    <= IDLE;
          end
        end
      endcase
    end
  end
endmodule

module clamp_fault_localizer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       detect_pulse,
  input logic [7:0] probe_gates,
  input logic       busy,
  input logic       done,
  input logic [7:0] fault_id
);
  p_idle_gates_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> probe_gates == 8'h00);
  p_done_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_id_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    fault_id != $past(fault_id) |-> done);
  p_id_legal_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (fault_id == 8'd0 || fault_id == 8'd3 || fault_id == 8'd9 ||
              fault_id == 8'd27 || fault_id == 8'd81 || $countones(fault_id) == 1));
  p_half_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ((probe_gates[7:4] == 4'b1100 || probe_gates[7:4] == 4'b0110 || probe_gates[7:4] == 4'b0011) &&
              (probe_gates[3:0] == 4'b1100 || probe_gates[3:0] == 4'b0110 || probe_gates[3:0] == 4'b0011)));
  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    detect_pulse && !busy |=> busy || done);
  p_busy_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> busy || done);
  p_one_half_moves_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && probe_gates != $past(probe_gates) |->
      ((probe_gates[7:4] == $past(probe_gates[7:4])) != (probe_gates[3:0] == $past(probe_gates[3:0]))));
endmodule

bind clamp_fault_localizer clamp_fault_localizer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .detect_pulse(detect_pulse), .probe_gates(probe_gates),
  .busy(busy), .done(done), .fault_id(fault_id)
);

// File: tb/sim_clamp_fault_localizer.sv
`timescale 1ns/1ps
module sim_clamp_fault_localizer;
  localparam int S = 2000;
  localparam int GLITCH = S / 2;
  localparam int WD_LIMIT = 190000;

  logic clk = 1'b0, rst_n = 1'b0, detect_pulse = 1'b0, cur_pos = 1'b0;
  logic [3:0] last_state = 4'd0;
  logic [2:0] level_code = 3'd2;
  logic [7:0] probe_gates, fault_id;
  logic busy, done;

  clamp_fault_localizer #(.SETTLE_CYC(S)) u0 (
    .clk(clk), .rst_n(rst_n), .detect_pulse(detect_pulse), .last_state(last_state),
    .cur_pos(cur_pos), .level_code(level_code), .probe_gates(probe_gates),
    .busy(busy), .done(done), .fault_id(fault_id));

  always #2.5 clk = ~clk;

  typedef struct { int kind; int val; string tag; } exp_t;
  exp_t q[$];
  int nchk = 0, nfail = 0, cyc = 0, t_start = 0;
  int lv[3];
  int sidx = -1, junk = 0;
  logic [7:0] plant_g = 8'h00, mon_g = 8'h00;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic take(input int kind, input int act);
    exp_t e;
    if (q.size() == 0 || q[0].kind != kind) begin
      chk(1'b0, "scoreboard: unexpected event", act, -1);
    end else begin
      e = q.pop_front();
      chk(act == e.val, e.tag, act, e.val);
    end
  endtask

  task automatic push(input int kind, input int val, input string tag);
    exp_t e;
    e.kind = kind; e.val = val; e.tag = tag;
    q.push_back(e);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD_LIMIT) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WD_LIMIT);
      $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  // power stage model: junk level after each gate change, then the scripted level
  always @(negedge clk) begin
    if (busy && probe_gates != plant_g) begin
      if (sidx < 2) sidx = sidx + 1;
      junk = GLITCH;
    end
    plant_g = busy ? probe_gates : 8'h00;
    if (junk > 0) begin
      level_code = 3'd7;
      junk = junk - 1;
    end else begin
      level_code = 3'(lv[(sidx < 0) ? 0 : sidx]);
    end
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy && probe_gates != mon_g) take(0, int'(probe_gates));
      mon_g = busy ? probe_gates : 8'h00;
      if (done) begin
        take(1, int'(fault_id));
        take(2, cyc - t_start);
      end
    end
  end

  task automatic run_case(input string tag, input int st, input bit pos,
                          input int l0, input int l1, input int l2,
                          input int g0, input int g1, input int g2,
                          input int n, input int exp_id, input bit extra);
    int gl[3];
    gl[0] = g0; gl[1] = g1; gl[2] = g2;
    lv[0] = l0; lv[1] = l1; lv[2] = l2;
    sidx = -1; junk = 0;
    for (int i = 0; i < n; i++)
      push(0, gl[i], (i == 0) ? {tag, " R2 state pattern"} : {tag, " probe gates"});
    push(1, exp_id, {tag, " R12 part code"});
    push(2, n * (S + 1) + 1, {tag, " R3 latency"});
    @(negedge clk);
    last_state = 4'(st); cur_pos = pos; detect_pulse = 1'b1; t_start = cyc;
    @(negedge clk);
    detect_pulse = 1'b0;
    if (extra) begin
      repeat (100) @(negedge clk);
      last_state = 4'd3; cur_pos = ~pos; detect_pulse = 1'b1;
      @(negedge clk);
      detect_pulse = 1'b0; last_state = 4'(st); cur_pos = pos;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(!done, {tag, " R13 done pulse"}, done, 0);
    chk(!busy, {tag, " R13 idle after done"}, busy, 0);
    chk(probe_gates == 8'h00, {tag, " R13 idle gates"}, probe_gates, 0);
    repeat (3) @(negedge clk);
    chk(fault_id == 8'(exp_id), {tag, " R13 id held"}, fault_id, exp_id);
    chk(q.size() == 0, {tag, " scoreboard drained"}, q.size(), 0);
  endtask

  initial begin
    lv[0] = 2; lv[1] = 2; lv[2] = 2;
    repeat (4) @(negedge clk);
    chk(!busy && !done, "R1 reset flags", {busy, done}, 0);
    chk(fault_id == 8'h00, "R1 reset id", fault_id, 0);
    chk(probe_gates == 8'h00, "R1 reset gates", probe_gates, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_case("R4 s2+ inner-top",     2, 1, 1, 0, 0, 'hC6, 0,     0,     1, 64,  0);
    run_case("R4 s3+ B inner-bottom", 3, 1, 1, 0, 0, 'h63, 0,     0,     1, 2,   0);
    run_case("R5 R11 s5+ B lower diode", 5, 1, 1, 2, 4, 'h66, 'hC6, 'hC3, 3, 81, 1);
    run_case("R5 s5+ B inner-bottom", 5, 1, 1, 2, 2, 'h66, 'hC6, 'hC3, 3, 2,   0);
    run_case("R5 s5+ A inner-top",   5, 1, 1, 1, 0, 'h66, 'hC6, 0,     2, 64,  0);
    run_case("R5 s5+ A upper diode", 5, 1, 1, 3, 0, 'h66, 'hC6, 0,     2, 3,   0);
    run_case("R6 s5- B upper diode", 5, 0, 3, 2, 0, 'h66, 'h36, 'h3C, 3, 27,  0);
    run_case("R6 s5- B inner-top",   5, 0, 3, 2, 2, 'h66, 'h36, 'h3C, 3, 4,   0);
    run_case("R6 s5- A lower diode", 5, 0, 3, 1, 0, 'h66, 'h36, 0,     2, 9,   0);
    run_case("R7 s2+ A outer-top",   2, 1, 2, 3, 0, 'hC6, 'hC3, 0,     2, 128, 0);
    run_case("R7 s2+ B lower diode", 2, 1, 2, 4, 0, 'hC6, 'hC3, 0,     2, 81,  0);
    run_case("R8 s8+ B inner-bottom", 8, 1, 0, 0, 0, 'h36, 'h33, 0,     2, 2,   0);
    run_case("R8 s8+ B lower diode", 8, 1, 0, 2, 0, 'h36, 'h33, 0,     2, 81,  0);
    run_case("R9 s1+ no probe left", 1, 1, 2, 0, 0, 'hC3, 0,     0,     1, 0,   0);
    run_case("R9 s2+ unmatched",     2, 1, 4, 0, 0, 'hC6, 0,     0,     1, 0,   0);
    run_case("R10 state 0",          0, 1, 2, 0, 0, 0,     0,     0,     0, 0,   0);
    run_case("R10 state 12",         12, 0, 2, 0, 0, 0,    0,     0,     0, 0,   0);

    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule